// File: doc/BRIEF.md
# 8-bit Register-ALU Datapath Core

This block is a single-cycle 8-bit datapath with no fetch stage. An instruction arrives on an 8-bit instruction port every clock: the upper four bits are the operation code and the lower four bits name the destination register. A second 8-bit operand port carries one of two things. For register operations it holds two 4-bit source register addresses. For a load it holds the data byte itself.

The core holds sixteen 8-bit registers, an eight-function ALU and a single carry flag. Results are written back on the clock edge that follows the instruction. A registered 8-bit output port shows either the contents of a register or the status byte. The output changes only on a store or a status read, and it holds its value through every other instruction. The core has no program counter, no external memory and no branching. A surrounding controller or testbench sequences the instructions directly.

Top module: `regalu_core`

## Requirements
- R1: A synchronous active-high reset clears all sixteen registers, the carry flag and the output to zero.
- R2: Opcode 0001 (load) writes the operand port byte into the register named by instruction bits 3:0.
- R3: Opcode 0010 (store) puts the register named by instruction bits 3:0 on the output after the next clock edge. No register and no flag changes.
- R4: Opcode 0000 (move) copies the register named by operand bits 7:4 into the register named by instruction bits 3:0.
- R5: Opcode 0011 (status read) sets the output to the carry flag in bit 0, with bits 7:1 zero.
- R6: Opcodes 0100 to 0111 change no register, the flag or the output, whatever the operand port carries.
- R7: With instruction bit 7 set, bits 6:4 select the ALU function. The binary codes AND 001, OR 010 and XOR 101 write (reg[operand 7:4] op reg[operand 3:0]) into reg[instruction 3:0].
- R8: The unary codes NOT 000 and INC 110 operate on reg[operand 7:4] alone. INC sets carry when its input is 0xFF.
- R9: ADD 011 writes the 8-bit sum modulo 256 and sets carry to the carry out of bit 7.
- R10: SUB 100 writes the first source minus the second, modulo 256, and sets carry to 1 exactly when a borrow occurs (first source less than second).
- R11: MUL 111 writes the low byte of the 16-bit product and sets carry when the high byte is non-zero.
- R12: The logic functions (NOT, AND, OR, XOR) clear carry. Opcodes with bit 7 clear leave carry unchanged.
- R13: The output holds its value during move, load, ALU and no-operation instructions.
- R14: The result of an instruction can be used by the very next instruction, in back-to-back dependent sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 8 | Opcode in bits 7:4, destination register in bits 3:0 |
| opnd_i | input | 8 | First source address in bits 7:4 and second in bits 3:0, or the load byte |
| dout_o | output | 8 | Registered store data or status byte |

## Verification
Some properties are checked by assertions on every cycle. The output stays fixed unless a store or status read is issued. A status read drives the upper seven output bits to zero. The carry flag stays fixed for every instruction with bit 7 clear, and a logic function always leaves carry clear. No-operation, store and status instructions never raise the register write enable. Other behaviour depends on data and can only be shown by the bench scenarios: arithmetic results, the carry and borrow values, the truncation of MUL, back-to-back dependent chains, and the contents of the registers after stray no-operations. The bench keeps its own model of the register file and compares every output sample against it.

// File: rtl/regalu_pkg.sv
`timescale 1ns/1ps
package regalu_pkg;

  localparam int OPC_W = 4;
  localparam int ALU_W = 3;

  localparam logic [OPC_W-1:0] OPC_MOVE  = 4'h0;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
  localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
  localparam logic [OPC_W-1:0] OPC_STAT  = 4'h3;

  typedef enum logic [ALU_W-1:0] {
    ALU_NOT = 3'd0,
    ALU_AND = 3'd1,
    ALU_OR  = 3'd2,
    ALU_ADD = 3'd3,
    ALU_SUB = 3'd4,
    ALU_XOR = 3'd5,
    ALU_INC = 3'd6,
    ALU_MUL = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    WB_REG = 2'd0,
    WB_IMM = 2'd1,
    WB_ALU = 2'd2
  } wb_sel_e;

  typedef struct packed {
    logic    rf_we;
    wb_sel_e wb_sel;
    logic    out_we;
    logic    out_stat;
    logic    flag_we;
    alu_op_e alu_op;
  } ctrl_t;

endpackage

// File: rtl/regalu_decode.sv
`timescale 1ns/1ps
module regalu_decode
  import regalu_pkg::*;
(
  input  logic [OPC_W-1:0] opc_i,
  output ctrl_t            ctrl_o
);

  always_comb begin
    ctrl_o.rf_we    = 1'b0;
    ctrl_o.wb_sel   = WB_REG;
    ctrl_o.out_we   = 1'b0;
    ctrl_o.out_stat = 1'b0;
    ctrl_o.flag_we  = 1'b0;
    ctrl_o.alu_op   = alu_op_e'(opc_i[ALU_W-1:0]);
    if (opc_i[OPC_W-1]) begin
      ctrl_o.rf_we   = 1'b1;
      ctrl_o.wb_sel  = WB_ALU;
      ctrl_o.flag_we = 1'b1;
    end else begin
      case (opc_i)
        OPC_MOVE: begin
          ctrl_o.rf_we  = 1'b1;
          ctrl_o.wb_sel = WB_REG;
        end
        OPC_LOAD: begin
          ctrl_o.rf_we  = 1'b1;
          ctrl_o.wb_sel = WB_IMM;
        end
        OPC_STORE: begin
          ctrl_o.out_we = 1'b1;
        end
        OPC_STAT: begin
          ctrl_o.out_we   = 1'b1;
          ctrl_o.out_stat = 1'b1;
        end
        default: begin
          ctrl_o.rf_we = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/regalu_regfile.sv
`timescale 1ns/1ps
module regalu_regfile #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4,
  parameter int N_RD   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              waddr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic [N_RD-1:0][ADDR_W-1:0]    raddr,
  output logic [N_RD-1:0][DATA_W-1:0]    rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i] <= '0;
      end
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    for (genvar p = 0; p < N_RD; p++) begin : g_rd
      assign rdata[p] = mem[raddr[p]];
    end
  endgenerate

endmodule

// File: rtl/regalu_alu.sv
`timescale 1ns/1ps
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] y_o,
  output logic              cout_o
);

  localparam int PROD_W = 2 * DATA_W;

  logic [DATA_W:0]   add_w;
  logic [DATA_W:0]   sub_w;
  logic [DATA_W:0]   inc_w;
  logic [PROD_W-1:0] prod_w;

  assign add_w  = {1'b0, a_i} + {1'b0, b_i};
  assign sub_w  = {1'b0, a_i} - {1'b0, b_i};
  assign inc_w  = {1'b0, a_i} + {{DATA_W{1'b0}}, 1'b1};
  assign prod_w = {{DATA_W{1'b0}}, a_i} * {{DATA_W{1'b0}}, b_i};

  always_comb begin
    y_o    = '0;
    cout_o = 1'b0;
    case (op_i)
      ALU_NOT: y_o = ~a_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_ADD: begin
        y_o    = add_w[DATA_W-1:0];
        cout_o = add_w[DATA_W];
      end
      ALU_SUB: begin
        y_o    = sub_w[DATA_W-1:0];
        cout_o = sub_w[DATA_W];
      end
      ALU_INC: begin
        y_o    = inc_w[DATA_W-1:0];
        cout_o = inc_w[DATA_W];
      end
      ALU_MUL: begin
        y_o    = prod_w[DATA_W-1:0];
        cout_o = |prod_w[PROD_W-1:DATA_W];
      end
      default: begin
        y_o    = '0;
        cout_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/regalu_core.sv
`timescale 1ns/1ps
module regalu_core
  import regalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [OPC_W+ADDR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]       opnd_i,
  output logic [DATA_W-1:0]       dout_o
);

  localparam int N_RD   = 3;
  localparam int RD_DST = 0;
  localparam int RD_SA  = 1;
  localparam int RD_SB  = 2;

  logic [OPC_W-1:0]              opc;
  logic [ADDR_W-1:0]             dst_addr;
  logic [ADDR_W-1:0]             sa_addr;
  logic [ADDR_W-1:0]             sb_addr;
  ctrl_t                         ctrl;
  logic                          rf_we;
  logic [N_RD-1:0][ADDR_W-1:0]   rd_addr;
  logic [N_RD-1:0][DATA_W-1:0]   rd_data;
  logic [DATA_W-1:0]             alu_y;
  logic                          alu_c;
  logic [DATA_W-1:0]             wb_data;
  logic                          carry_q;
  logic [DATA_W-1:0]             dout_q;

  assign opc      = instr_i[OPC_W+ADDR_W-1:ADDR_W];
  assign dst_addr = instr_i[ADDR_W-1:0];
  assign sa_addr  = opnd_i[2*ADDR_W-1:ADDR_W];
  assign sb_addr  = opnd_i[ADDR_W-1:0];

  regalu_decode u_dec (
    .opc_i  (opc),
    .ctrl_o (ctrl)
  );

  assign rf_we           = ctrl.rf_we;
  assign rd_addr[RD_DST] = dst_addr;
  assign rd_addr[RD_SA]  = sa_addr;
  assign rd_addr[RD_SB]  = sb_addr;

  regalu_regfile #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .N_RD   (N_RD)
  ) u_rf (
    .clk   (clk),
    .rst   (rst),
    .we    (rf_we),
    .waddr (dst_addr),
    .wdata (wb_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  regalu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .a_i    (rd_data[RD_SA]),
    .b_i    (rd_data[RD_SB]),
    .op_i   (ctrl.alu_op),
    .y_o    (alu_y),
    .cout_o (alu_c)
  );

  always_comb begin
    case (ctrl.wb_sel)
      WB_IMM:  wb_data = opnd_i;
      WB_ALU:  wb_data = alu_y;
      default: wb_data = rd_data[RD_SA];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      carry_q <= 1'b0;
    end else if (ctrl.flag_we) begin
      carry_q <= alu_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
    end else if (ctrl.out_we) begin
      if (ctrl.out_stat) begin
        dout_q <= {{(DATA_W-1){1'b0}}, carry_q};
      end else begin
        dout_q <= rd_data[RD_DST];
      end
    end
  end

  assign dout_o = dout_q;

endmodule

// File: rtl/regalu_core_chk.sv
`timescale 1ns/1ps
module regalu_core_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W+3:0]   instr_i,
  input logic [DATA_W-1:0]   dout_o,
  input logic                carry_q,
  input logic                rf_we
);

  logic [3:0] opc;
  assign opc = instr_i[ADDR_W+3:ADDR_W];

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout_o == '0 && carry_q == 1'b0));

  // R5
  stat_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'h3) |=> (dout_o[DATA_W-1:1] == '0));

  // R13
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != 4'h2 && opc != 4'h3) |=> $stable(dout_o));

  // R12
  carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!opc[3]) |=> $stable(carry_q));

  // R12
  logic_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'h8 || opc == 4'h9 || opc == 4'hA || opc == 4'hD) |=> !carry_q);

  // R6
  nop_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (opc[3:2] == 2'b01) |-> !rf_we);

  // R3
  store_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == 4'h2 || opc == 4'h3) |-> !rf_we);

endmodule

bind regalu_core regalu_core_chk #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .instr_i (instr_i),
  .dout_o  (dout_o),
  .carry_q (carry_q),
  .rf_we   (rf_we)
);

// File: tb/regalu_core_bench.sv
`timescale 1ns/1ps
module regalu_core_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] instr;
  logic [7:0] opnd;
  logic [7:0] dout;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_reg [16];
  logic       m_c;
  logic [7:0] m_dout;

  logic [7:0] exp_q [$];
  string      tag_q [$];
  logic [7:0] mon_e;
  string      mon_t;

  always #(CLK_PERIOD/2) clk = ~clk;

  regalu_core u_regalu_core (
    .clk     (clk),
    .rst     (rst),
    .instr_i (instr),
    .opnd_i  (opnd),
    .dout_o  (dout)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // Driver: applies one instruction and pushes the expected output.
  task automatic issue(input logic [3:0] opc, input logic [3:0] dst,
                       input logic [7:0] op, input string tag);
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] w;
    @(negedge clk);
    instr = {opc, dst};
    opnd  = op;
    a = m_reg[op[7:4]];
    b = m_reg[op[3:0]];
    if (opc[3]) begin
      case (opc[2:0])
        3'd0: begin m_reg[dst] = ~a;    m_c = 1'b0; end
        3'd1: begin m_reg[dst] = a & b; m_c = 1'b0; end
        3'd2: begin m_reg[dst] = a | b; m_c = 1'b0; end
        3'd5: begin m_reg[dst] = a ^ b; m_c = 1'b0; end
        3'd3: begin w = 16'(a) + 16'(b); m_reg[dst] = w[7:0]; m_c = w[8]; end
        3'd4: begin m_reg[dst] = a - b;  m_c = (a < b); end
        3'd6: begin m_reg[dst] = a + 8'd1; m_c = (a == 8'hFF); end
        default: begin w = 16'(a) * 16'(b); m_reg[dst] = w[7:0]; m_c = (w[15:8] != 8'h00); end
      endcase
    end else begin
      case (opc)
        4'h0: m_reg[dst] = a;
        4'h1: m_reg[dst] = op;
        4'h2: m_dout = m_reg[dst];
        4'h3: m_dout = {7'b0, m_c};
        default: ;
      endcase
    end
    exp_q.push_back(m_dout);
    tag_q.push_back(tag);
  endtask

  task automatic ld(input logic [3:0] d, input logic [7:0] v, input string tag);
    issue(4'h1, d, v, tag);
  endtask

  task automatic st(input logic [3:0] d, input string tag);
    issue(4'h2, d, 8'h00, tag);
  endtask

  task automatic rds(input string tag);
    issue(4'h3, 4'h0, 8'h00, tag);
  endtask

  task automatic alu(input logic [2:0] code, input logic [3:0] d, input logic [3:0] sa,
                     input logic [3:0] sb, input string tag);
    issue({1'b1, code}, d, {sa, sb}, tag);
  endtask

  // Monitor: compares the output one step after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      mon_e = exp_q.pop_front();
      mon_t = tag_q.pop_front();
      checks++;
      if (dout !== mon_e) begin
        errors++;
        $display("FAIL %s: dout=%02h expected %02h", mon_t, dout, mon_e);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_c    = 1'b0;
    m_dout = 8'h00;
    rst    = 1'b1;
    instr  = 8'h40;
    opnd   = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dout !== 8'h00) begin
      errors++;
      $display("FAIL R1 output after reset: dout=%02h expected 00", dout);
    end
    rst = 1'b0;

    // R1: all registers and the flag cleared
    for (int i = 0; i < 16; i++) st(4'(i), "R1 register cleared");
    rds("R1 carry cleared");

    // R2 loads, R14 immediate use
    ld(4'd1, 8'h3C, "R13 hold on load");
    st(4'd1, "R14 load then store");
    ld(4'd2, 8'hA5, "R13");
    ld(4'd3, 8'hFF, "R13");
    ld(4'd4, 8'h01, "R13");
    ld(4'd5, 8'h10, "R13");
    ld(4'd6, 8'h20, "R13");
    st(4'd2, "R2 load byte");
    st(4'd3, "R2 load byte");

    // R4 move
    issue(4'h0, 4'd7, {4'd2, 4'd0}, "R13 hold on move");
    st(4'd7, "R4 move copy");

    // R9 add
    alu(3'd3, 4'd8, 4'd3, 4'd4, "R13 hold on alu");
    rds("R9 carry out set");
    st(4'd8, "R9 sum wraps");
    alu(3'd3, 4'd8, 4'd1, 4'd2, "R13");
    rds("R5 status byte no carry");
    st(4'd8, "R9 sum");

    // R10 sub
    alu(3'd4, 4'd9, 4'd4, 4'd3, "R13");
    rds("R10 borrow set");
    st(4'd9, "R10 difference wraps");
    alu(3'd4, 4'd9, 4'd3, 4'd4, "R13");
    rds("R10 no borrow");
    st(4'd9, "R10 difference");
    alu(3'd4, 4'd9, 4'd2, 4'd2, "R13");
    rds("R10 equal operands no borrow");
    st(4'd9, "R10 zero difference");

    // R11 mul
    alu(3'd7, 4'd10, 4'd5, 4'd6, "R13");
    rds("R11 high byte nonzero");
    st(4'd10, "R11 low byte");
    alu(3'd7, 4'd10, 4'd1, 4'd4, "R13");
    rds("R11 high byte zero");
    st(4'd10, "R11 low byte");

    // R8 inc with carry, then R7 logic with R12 clearing carry
    alu(3'd6, 4'd11, 4'd3, 4'd0, "R13");
    rds("R8 inc carry");
    st(4'd11, "R8 inc wraps");
    alu(3'd1, 4'd12, 4'd1, 4'd2, "R13");
    rds("R12 and clears carry");
    st(4'd12, "R7 and");
    alu(3'd6, 4'd13, 4'd3, 4'd0, "R13");
    alu(3'd2, 4'd13, 4'd1, 4'd2, "R13");
    rds("R12 or clears carry");
    st(4'd13, "R7 or");
    alu(3'd6, 4'd14, 4'd3, 4'd0, "R13");
    alu(3'd5, 4'd14, 4'd1, 4'd2, "R13");
    rds("R12 xor clears carry");
    st(4'd14, "R7 xor");
    alu(3'd6, 4'd15, 4'd3, 4'd0, "R13");
    alu(3'd0, 4'd15, 4'd2, 4'd0, "R13");
    rds("R12 not clears carry");
    st(4'd15, "R8 not");
    alu(3'd6, 4'd15, 4'd1, 4'd0, "R13");
    st(4'd15, "R8 inc");

    // R12 carry kept by non-ALU ops; R6 no-operations
    alu(3'd6, 4'd11, 4'd3, 4'd0, "R13");
    ld(4'd0, 8'h77, "R13");
    issue(4'h0, 4'd5, {4'd0, 4'd0}, "R13");
    st(4'd5, "R4 move after load");
    for (int k = 4; k < 8; k++) issue(4'(k), 4'd1, 8'hFF, "R6 output held on nop");
    rds("R12 carry kept");
    for (int k = 4; k < 8; k++) issue(4'(k), 4'd0, 8'h12, "R6 output held on nop");
    st(4'd1, "R6 register unchanged by nop");
    st(4'd0, "R6 register unchanged by nop");

    // R14 dependent chain
    ld(4'd2, 8'h05, "R13");
    alu(3'd3, 4'd3, 4'd2, 4'd2, "R13");
    alu(3'd7, 4'd4, 4'd3, 4'd3, "R13");
    alu(3'd6, 4'd4, 4'd4, 4'd0, "R13");
    st(4'd4, "R14 chained result");
    rds("R14 chained carry");

    // R3 stores leave every register as modelled
    for (int i = 0; i < 16; i++) st(4'(i), "R3 register file intact");

    @(posedge clk);
    #2;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 pending results: actual=%0d expected=0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule